// File: doc/BRIEF.md
# Three-Wire Codec Control Bus Master

This block drives a three-line serial control bus of the kind used to set up audio codecs: a serial clock, a bidirectional data line and a mode line. A local agent hands it one request at a time through a valid/ready handshake. Each request names a 6-bit device address, a 2-bit register-type code, a direction, and a payload of one or two bytes. Writes take their payload from the request; reads return the bytes the device shifts back on `rd_data`.

Every bus phase is timed from parameters counted in system clock cycles: clock-low, clock-high, mode setup, mode hold and the inter-byte halt. A transaction raises all three lines, sends the address byte with the mode line low, then moves every data byte with the mode line high. A timed clock-low halt goes before each data byte after the first. For reads the block releases the data line once the address byte is done and samples it on the last clock-low cycle of each bit. When the bus returns low, the block pulses `done` for one cycle.

Top module: `cbus3_master`

## Requirements
- R1: Out of reset, and whenever no transaction is in flight, `bus_clk`, `bus_mode`, `bus_data_out` and `bus_data_oe` are all 0, `req_ready` is 1 and `busy` is 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge), all three bus lines are driven high with `bus_data_oe` = 1, and they stay high for T_SETUP cycles.
- R3: The first byte is `{req_addr, req_type}` (address in bits 7:2, type in bits 1:0), and every byte is shifted out least significant bit first.
- R4: Each bit is a clock-low phase of exactly T_LOW cycles followed by a clock-high phase of exactly T_HIGH cycles. The data line changes only when the clock falls.
- R5: Each byte is preceded by T_SETUP cycles and followed by T_HOLD cycles with the clock high.
- R6: The mode line is 0 throughout the address byte and 1 throughout every data byte. It never changes while the clock stays low.
- R7: Before the second data byte, the clock is held low for exactly T_HALT cycles, then goes high for that byte's setup.
- R8: In a read, `bus_data_oe` drops at the start of the first data byte's setup and stays 0 to the end. Each bit is taken from `bus_data_in` in the last clock-low cycle of that bit, and data byte k lands in `rd_data[8k+7:8k]`.
- R9: `req_len` = 1 moves one data byte and `req_len` = 2 moves two. On a one-byte read, the upper byte of `rd_data` is 0.
- R10: `req_ready` is high only while idle, and requests made while busy are ignored. `done` is a single-cycle pulse in the first idle cycle after a transaction, and a new request may be accepted in that cycle.
- R11: Write payload bytes are captured when the request is accepted. Later changes on `req_wdata` do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W (6) | Device address |
| req_type | input | TYPE_W (2) | Register-type code |
| req_len | input | $clog2(PAY_MAX+1) (2) | Data byte count; 0 is taken as 1 and values above PAY_MAX are capped |
| req_wdata | input | 8*PAY_MAX (16) | Write payload, data byte k in bits 8k+7:8k |
| rd_data | output | 8*PAY_MAX (16) | Read result, updated when a read ends |
| busy | output | 1 | Transaction in flight |
| done | output | 1 | One-cycle pulse on return to idle |
| bus_clk | output | 1 | Serial clock |
| bus_mode | output | 1 | Mode line: 0 address, 1 data |
| bus_data_out | output | 1 | Data line output value |
| bus_data_oe | output | 1 | Data line output enable |
| bus_data_in | input | 1 | Data line input value |

## Verification
The bench targets the seams between phases. It checks the halt that appears only before the second data byte: a design that also halted before the first byte, or never halted, would shift the whole clock pattern. It checks the one-cycle hold with T_HOLD = 1: an off-by-one counter would stretch or drop it. During read bits it drives the wrong value on `bus_data_in` in every low cycle except the last, so sampling at the wrong moment returns corrupted bytes. It also checks the return to high-impedance at the address/data seam. It changes `req_wdata` and raises `req_valid` in the middle of a transfer, and issues a request back-to-back in the `done` cycle. A design that did not latch the payload, accepted while busy, or missed the early acceptance would send different bytes or a different waveform.

// File: rtl/cbus3_pkg.sv
package cbus3_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_SETUP,
      PH_BLOW,
      PH_BHIGH,
      PH_HOLD,
      PH_HALT
   } cb_phase_e;

   function automatic int cb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cbus3_tick.sv
module cbus3_tick #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expire
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expire = (cnt_q == '0);
endmodule

// File: rtl/cbus3_payload.sv
module cbus3_payload #(
   parameter int ADDR_W  = 6,
   parameter int TYPE_W  = 2,
   parameter int PAY_MAX = 2,
   parameter int BW      = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [TYPE_W-1:0]     rtype,
   input  logic [8*PAY_MAX-1:0]  wdata,
   input  logic [BW-1:0]         byte_sel,
   output logic [7:0]            tx_byte,
   input  logic                  smp,
   input  logic                  din,
   input  logic                  commit,
   input  logic [BW-1:0]         nlast,
   output logic [8*PAY_MAX-1:0]  rd_data
);
   localparam int PW = 8 * PAY_MAX;

   logic [ADDR_W-1:0] addr_q;
   logic [TYPE_W-1:0] type_q;
   logic [PW-1:0]     wd_q;
   logic [PW-1:0]     rx_q;
   logic [PW-1:0]     rd_q;
   logic [7:0]        byte_tab [PAY_MAX+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         type_q <= '0;
         wd_q   <= '0;
      end else if (cap) begin
         addr_q <= addr;
         type_q <= rtype;
         wd_q   <= wdata;
      end
   end

   assign byte_tab[0] = {addr_q, type_q};
   genvar g;
   generate
      for (g = 0; g < PAY_MAX; g++) begin : g_pay
         assign byte_tab[g+1] = wd_q[g*8 +: 8];
      end
   endgenerate

   assign tx_byte = byte_tab[byte_sel];

   // bits arrive LSB first; shift in from the top and realign at the end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_q <= '0;
      else if (cap)
         rx_q <= '0;
      else if (smp)
         rx_q <= {din, rx_q[PW-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else if (commit)
         rd_q <= rx_q >> (8 * (PAY_MAX - int'(nlast)));
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/cbus3_seq.sv
module cbus3_seq
   import cbus3_pkg::*;
#(
   parameter int T_LOW   = 4,
   parameter int T_HIGH  = 4,
   parameter int T_SETUP = 2,
   parameter int T_HOLD  = 2,
   parameter int T_HALT  = 6,
   parameter int CW      = 3,
   parameter int BW      = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_read,
   input  logic [BW-1:0] nlast,
   input  logic          expire,
   input  logic [7:0]    tx_byte,
   output logic          load,
   output logic [CW-1:0] load_val,
   output logic [BW-1:0] byte_sel,
   output logic [BW-1:0] last_sel,
   output logic          idle,
   output logic          smp,
   output logic          commit,
   output logic          done,
   output logic          ck,
   output logic          md,
   output logic          dq,
   output logic          oe
);
   cb_phase_e phase_q, phase_d;
   logic [2:0]    bit_q;
   logic          rd_q;
   logic [BW-1:0] byte_q;
   logic [BW-1:0] last_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:  if (start) phase_d = PH_START;
         PH_START: if (expire) phase_d = PH_SETUP;
         PH_SETUP: if (expire) phase_d = PH_BLOW;
         PH_BLOW:  if (expire) phase_d = PH_BHIGH;
         PH_BHIGH: if (expire) phase_d = (bit_q == 3'd7) ? PH_HOLD : PH_BLOW;
         PH_HOLD:
            if (expire) begin
               if (byte_q == last_q)    phase_d = PH_IDLE;
               else if (byte_q == '0)   phase_d = PH_SETUP;
               else                     phase_d = PH_HALT;
            end
         PH_HALT:  if (expire) phase_d = PH_SETUP;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_comb begin
      unique case (phase_d)
         PH_START, PH_SETUP: load_val = CW'(T_SETUP - 1);
         PH_BLOW:            load_val = CW'(T_LOW - 1);
         PH_BHIGH:           load_val = CW'(T_HIGH - 1);
         PH_HOLD:            load_val = CW'(T_HOLD - 1);
         PH_HALT:            load_val = CW'(T_HALT - 1);
         default:            load_val = '0;
      endcase
   end

   assign load   = (phase_d != phase_q);
   assign smp    = (phase_q == PH_BLOW) && expire && rd_q && (byte_q != '0);
   assign commit = (phase_q == PH_HOLD) && expire && (byte_q == last_q) && rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bit_q   <= '0;
         byte_q  <= '0;
         last_q  <= '0;
         rd_q    <= 1'b0;
         done    <= 1'b0;
         ck      <= 1'b0;
         md      <= 1'b0;
         dq      <= 1'b0;
         oe      <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= 1'b0;
         unique case (phase_q)
            PH_IDLE:
               if (start) begin
                  byte_q <= '0;
                  last_q <= nlast;
                  rd_q   <= is_read;
                  {ck, md, dq, oe} <= 4'b1111;
               end
            PH_START:
               if (expire) md <= 1'b0;
            PH_SETUP:
               if (expire) begin
                  ck    <= 1'b0;
                  bit_q <= '0;
                  if (oe) dq <= tx_byte[0];
               end
            PH_BLOW:
               if (expire) ck <= 1'b1;
            PH_BHIGH:
               if (expire && bit_q != 3'd7) begin
                  ck    <= 1'b0;
                  bit_q <= bit_q + 3'd1;
                  if (oe) dq <= tx_byte[bit_q + 3'd1];
               end
            PH_HOLD:
               if (expire) begin
                  if (byte_q == last_q) begin
                     {ck, md, dq, oe} <= 4'b0000;
                     done <= 1'b1;
                  end else begin
                     byte_q <= byte_q + 1'b1;
                     md     <= 1'b1;
                     oe     <= ~rd_q;
                     if (byte_q != '0) ck <= 1'b0;
                  end
               end
            PH_HALT:
               if (expire) ck <= 1'b1;
            default: ;
         endcase
      end
   end

   assign byte_sel = byte_q;
   assign last_sel = last_q;
   assign idle     = (phase_q == PH_IDLE);
endmodule

// File: rtl/cbus3_master.sv
module cbus3_master
   import cbus3_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int TYPE_W  = 2,
   parameter int PAY_MAX = 2,
   parameter int T_LOW   = 4,
   parameter int T_HIGH  = 4,
   parameter int T_SETUP = 2,
   parameter int T_HOLD  = 2,
   parameter int T_HALT  = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic                          req_read,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [TYPE_W-1:0]             req_type,
   input  logic [$clog2(PAY_MAX+1)-1:0]  req_len,
   input  logic [8*PAY_MAX-1:0]          req_wdata,
   output logic [8*PAY_MAX-1:0]          rd_data,
   output logic                          busy,
   output logic                          done,
   output logic                          bus_clk,
   output logic                          bus_mode,
   output logic                          bus_data_out,
   output logic                          bus_data_oe,
   input  logic                          bus_data_in
);
   localparam int BW   = $clog2(PAY_MAX + 1);
   localparam int TMAX = cb_max(cb_max(T_LOW, T_HIGH),
                                cb_max(cb_max(T_SETUP, T_HOLD), T_HALT));
   localparam int CW   = (TMAX <= 2) ? 1 : $clog2(TMAX);

   generate
      if (ADDR_W + TYPE_W != 8) begin : g_bad_hdr
         $error("address and type fields must fill one byte");
      end
      if (PAY_MAX < 1) begin : g_bad_pay
         $error("PAY_MAX must be at least 1");
      end
      if (T_LOW < 1 || T_HIGH < 1 || T_SETUP < 1 || T_HOLD < 1 || T_HALT < 1) begin : g_bad_time
         $error("every timing period must be at least one cycle");
      end
   endgenerate

   logic          idle, start, expire, load, smp, commit;
   logic [CW-1:0] load_val;
   logic [BW-1:0] byte_sel, last_sel, len_c;
   logic [7:0]    tx_byte;

   always_comb begin
      if (req_len == '0)                  len_c = BW'(1);
      else if (int'(req_len) > PAY_MAX)   len_c = BW'(PAY_MAX);
      else                                len_c = req_len;
   end

   assign start     = req_valid && idle;
   assign req_ready = idle;
   assign busy      = ~idle;

   cbus3_tick #(.CW(CW)) u_tick (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expire(expire)
   );

   cbus3_payload #(
      .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .PAY_MAX(PAY_MAX), .BW(BW)
   ) u_payload (
      .clk(clk), .rst_n(rst_n), .cap(start), .addr(req_addr), .rtype(req_type),
      .wdata(req_wdata), .byte_sel(byte_sel), .tx_byte(tx_byte), .smp(smp),
      .din(bus_data_in), .commit(commit), .nlast(last_sel), .rd_data(rd_data)
   );

   cbus3_seq #(
      .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD),
      .T_HALT(T_HALT), .CW(CW), .BW(BW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_read(req_read), .nlast(len_c),
      .expire(expire), .tx_byte(tx_byte), .load(load), .load_val(load_val),
      .byte_sel(byte_sel), .last_sel(last_sel), .idle(idle), .smp(smp),
      .commit(commit), .done(done), .ck(bus_clk), .md(bus_mode),
      .dq(bus_data_out), .oe(bus_data_oe)
   );
endmodule

// File: rtl/cbus3_master_chk.sv
module cbus3_master_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic busy,
   input logic done,
   input logic bus_clk,
   input logic bus_mode,
   input logic bus_data_out,
   input logic bus_data_oe
);
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_clk && !bus_mode && !bus_data_out && !bus_data_oe));

   a_r2_start_high: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (bus_clk && bus_mode && bus_data_out && bus_data_oe));

   a_r4_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_clk && $past(bus_clk) && bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_out));

   a_r6_mode_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_clk && $past(!bus_clk)) |-> $stable(bus_mode));

   a_r8_release_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_data_oe) && busy) |-> (bus_clk && bus_mode));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && !bus_clk));
endmodule

bind cbus3_master cbus3_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .busy(busy), .done(done), .bus_clk(bus_clk), .bus_mode(bus_mode),
   .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe)
);

// File: tb/cbus3_master_tb.sv
module cbus3_master_tb;
   localparam int TL = 2, TH = 3, TS = 2, TO = 1, TA = 4;

   typedef struct packed {
      logic ck, md, dt, oe, dn, rbv, rbo;
      logic [3:0] rbi;
      logic [3:0] kind;
   } ent_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_read = 1'b0, bus_data_in = 1'b0;
   logic [5:0] req_addr = '0;
   logic [1:0] req_type = '0, req_len = 2'd1;
   logic [15:0] req_wdata = '0, rd_data, resp = '0, exp_rd = '0;
   logic req_ready, busy, done, bus_clk, bus_mode, bus_data_out, bus_data_oe;

   int checks = 0, fails = 0;
   bit fin = 1'b0, acc_now = 1'b0, prev_ready = 1'b1, exp_rd_one = 1'b0;
   ent_t q[$];

   always #10 clk = ~clk;

   cbus3_master #(.T_LOW(TL), .T_HIGH(TH), .T_SETUP(TS), .T_HOLD(TO), .T_HALT(TA)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_read(req_read), .req_addr(req_addr), .req_type(req_type), .req_len(req_len),
      .req_wdata(req_wdata), .rd_data(rd_data), .busy(busy), .done(done),
      .bus_clk(bus_clk), .bus_mode(bus_mode), .bus_data_out(bus_data_out),
      .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in)
   );

   function automatic string tag(input logic [3:0] k);
      case (k)
         4'd2: return "R2";  4'd3: return "R3";  4'd5: return "R5";
         4'd7: return "R7";  4'd8: return "R8";  4'd10: return "R10";
         4'd11: return "R11"; default: return "R1";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic put(input logic ck, md, dt, oe, dn, rbv, rbo, input int rbi, input int kind, input int n);
      ent_t e;
      for (int i = 0; i < n; i++) begin
         e = '{ck:ck, md:md, dt:dt, oe:oe, dn:dn, rbv:(rbv && i == n-1), rbo:(rbo && i != n-1),
               rbi:4'(rbi), kind:4'(kind)};
         q.push_back(e);
      end
   endtask

   // behavioural waveform of one transaction, one entry per system clock cycle
   task automatic plan(input logic rd, input logic [5:0] a, input logic [1:0] t,
                       input logic [1:0] len, input logic [15:0] wd);
      logic d = 1'b1;
      int nb = (len == 2'd2) ? 2 : 1;
      put(1, 1, 1, 1, 0, 0, 0, 0, 2, TS);                          // R2
      for (int b = 0; b <= nb; b++) begin
         logic [7:0] v = (b == 0) ? {a, t} : wd[(b-1)*8 +: 8];
         logic md = (b != 0);
         logic oe = (b == 0) || !rd;
         int kb = (b == 0) ? 3 : (rd ? 8 : 11);
         if (b == 2) put(0, 1, d, oe, 0, 0, 0, 0, 7, TA);           // R7 halt
         put(1, md, d, oe, 0, 0, 0, 0, 5, TS);                       // R5 setup
         for (int i = 0; i < 8; i++) begin
            if (oe) d = v[i];
            put(0, md, d, oe, 0, rd && b != 0, rd && b != 0, (b-1)*8 + i, kb, TL);
            put(1, md, d, oe, 0, 0, 0, 0, kb, TH);                   // R4 high phase
         end
         put(1, md, d, oe, 0, 0, 0, 0, 5, TO);                       // R5 hold
      end
      put(0, 0, 0, 0, 1, 0, 0, 0, 10, 1);                           // R10 done
      exp_rd_one = rd && nb == 1;
      exp_rd = rd ? ((nb == 1) ? {8'h00, resp[7:0]} : resp) : rd_data;
   endtask

   // reference model and comparison, once per cycle, away from the active edge
   always @(negedge clk) begin
      ent_t e;
      string r;
      if (rst_n) begin
         acc_now = req_valid && prev_ready;
         if (acc_now) plan(req_read, req_addr, req_type, req_len, req_wdata);
         if (q.size() > 0) e = q.pop_front();
         else e = '{ck:0, md:0, dt:0, oe:0, dn:0, rbv:0, rbo:0, rbi:0, kind:1};
         if (e.rbv)      bus_data_in = resp[e.rbi];
         else if (e.rbo) bus_data_in = ~resp[e.rbi];
         else            bus_data_in = 1'b0;
         r = tag(e.kind);
         chk(bus_clk == e.ck, (e.kind == 1) ? r : "R4", "bus_clk", bus_clk, e.ck);
         chk(bus_mode == e.md, (e.kind == 1) ? r : "R6", "bus_mode", bus_mode, e.md);
         chk(bus_data_oe == e.oe, (e.kind == 1) ? r : "R8", "bus_data_oe", bus_data_oe, e.oe);
         if (e.oe) chk(bus_data_out == e.dt, r, "bus_data_out", bus_data_out, e.dt);
         chk(done == e.dn, "R10", "done", done, e.dn);
         chk(req_ready == (q.size() == 0), "R10", "req_ready", req_ready, q.size() == 0);
         if (e.dn) chk(rd_data == exp_rd, exp_rd_one ? "R9" : "R8", "rd_data", rd_data, exp_rd);
         prev_ready = (q.size() == 0);
      end
   end

   task automatic send(input logic rd, input logic [5:0] a, input logic [1:0] t,
                       input logic [1:0] len, input logic [15:0] wd);
      @(negedge clk); #1;
      req_valid = 1'b1; req_read = rd; req_addr = a; req_type = t; req_len = len; req_wdata = wd;
      do begin @(negedge clk); #2; end while (!acc_now);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do begin @(negedge clk); #2; end while (q.size() != 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(!bus_clk && !bus_mode && !bus_data_out && !bus_data_oe, "R1", "bus lines in reset",
          {bus_clk, bus_mode, bus_data_out, bus_data_oe}, 0);
      chk(req_ready && !busy && !done, "R1", "handshake in reset", {req_ready, busy, done}, 3'b100);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);

      send(1'b0, 6'h05, 2'b10, 2'd1, 16'h00A6); wait_idle();        // R3 R9 one-byte write
      send(1'b0, 6'h3F, 2'b01, 2'd2, 16'h5AC3);                     // R7 R11 two-byte write
      req_wdata = 16'hFFFF; req_valid = 1'b1; req_read = 1'b1;      // R10 R11 ignored while busy
      repeat (5) @(negedge clk);
      #1 req_valid = 1'b0;
      wait_idle();
      resp = 16'h0096; send(1'b1, 6'h2A, 2'b00, 2'd1, 16'h0000); wait_idle();   // R8 R9
      resp = 16'h3CE1; send(1'b1, 6'h11, 2'b11, 2'd2, 16'h0000); wait_idle();   // R8 two bytes
      send(1'b0, 6'h00, 2'b00, 2'd2, 16'h0000);                     // R10 back-to-back
      send(1'b0, 6'h3F, 2'b11, 2'd2, 16'hFFFF); wait_idle();
      resp = 16'hA55A; send(1'b1, 6'h01, 2'b10, 2'd0, 16'h0000); wait_idle();   // R9 length 0 as 1
      fin = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         fails++;
         $display("FAIL R10 watchdog: actual hung expected idle");
         summary();
         $finish;
      end
   end
endmodule